// File: doc/BRIEF.md
# Event Framing Word Parser

This block takes the 16-bit word stream from one readout board and turns it into 64-bit event words. It collects every four accepted input words into one group, with the first word in the lowest 16 bits. Each completed group is presented on a valid/ready output together with framing flags. Bit 15 marks a control word, and the top nibble of a control word gives its code. The block tracks where it is inside an event from these codes. It rejects groups that are malformed or out of order, and it checks the trailers against the header contents.

From the first header group it captures the 24-bit trigger number and the 12-bit bunch-crossing number. From the second header group it captures the crate number and the board ID. These values stay on the `ev_*` outputs until the next header overwrites them. A lone group is a complete event with no payload. A header pair, then any number of payload groups, then a trailer pair, forms a full event. Only four-word groups exist, so an event whose length is not a multiple of four words shows up as a group that mixes data and control words.

Top module: `evt_frame_parser`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and all `ev_*` outputs are 0.
- R2: The four accepted words of a group appear in `out_data` in arrival order: the first in [15:0], the second in [31:16], the third in [47:32] and the fourth in [63:48]. `out_valid` rises on the clock edge after the fourth word is accepted.
- R3: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output word and its flags stay unchanged.
- R4: A group is a control group when any of its words has bit 15 set. If the four top nibbles of a control group are not all equal, `out_err_frame` is set. `out_last` is set if an event was open. The parser then waits for a new event.
- R5: Outside an event, a code-0x9 group opens an event and a code-0x8 group is accepted. Any other group sets `out_err_seq`, does not set `out_last`, and leaves the parser outside an event.
- R6: A code-0x8 lone group sets `out_lone` and `out_last`. It loads `ev_trig` with {word b[11:0], word a[11:0]} and `ev_bxn` with word d[11:0].
- R7: A code-0x9 group loads `ev_trig` with {b[11:0], a[11:0]} and `ev_bxn` with d[11:0]. The next group must have code 0xA, which loads `ev_crate` from b[11:4] and `ev_board` from b[3:0]. Any other group in that position sets `out_err_seq` and `out_last` and closes the event.
- R8: Inside the event body, data groups pass through, and so do control groups with codes other than 0x8, 0x9, 0xA, 0xE and 0xF. Codes 0x8, 0x9, 0xA and 0xE set `out_err_seq` and `out_last` and close the event. Code 0xF moves the parser to the final-trailer position.
- R9: The group after a code-0xF group always sets `out_last` and closes the event. If that group is not a code-0xE group, `out_err_seq` is also set.
- R10: `out_err_match` is set on a code-0xF group whose word a[7:0] differs from `ev_trig[7:0]`. It is also set on a code-0xE group (in trailer position) whose word b[11:0] differs from {`ev_crate`, `ev_board`}. Neither mismatch closes the event early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_word | input | 16 | Input word; bit 15 marks a control word |
| out_valid | output | 1 | Output group present |
| out_ready | input | 1 | Consumer takes the output group |
| out_data | output | 64 | Four grouped input words |
| out_last | output | 1 | Group closes an event |
| out_lone | output | 1 | Group is a lone event |
| out_err_frame | output | 1 | Mixed or inconsistent control group |
| out_err_seq | output | 1 | Group out of order |
| out_err_match | output | 1 | Trailer disagrees with header |
| ev_trig | output | 24 | Captured trigger number |
| ev_bxn | output | 12 | Captured bunch-crossing number |
| ev_crate | output | 8 | Captured crate number |
| ev_board | output | 4 | Captured board ID |

## Verification
The bench builds the parser with its default code parameters: 0x8 for lone, 0x9 and 0xA for the headers, 0xF and 0xE for the trailers. Every ordering rule can therefore be written in these literal nibbles. With gaps in the input and periodic output stalls, groups complete while the output register is still occupied. This exercises the hold and back-pressure path of the shared ready, alongside clean events, lone events, missing or misplaced trailers, mixed groups and header/trailer disagreements.

// File: rtl/evt_frame_parser.sv
module evt_frame_parser #(
  parameter logic [3:0] LONE_CODE = 4'h8,
  parameter logic [3:0] HDR1_CODE = 4'h9,
  parameter logic [3:0] HDR2_CODE = 4'hA,
  parameter logic [3:0] TRL1_CODE = 4'hF,
  parameter logic [3:0] TRL2_CODE = 4'hE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic        out_last,
  output logic        out_lone,
  output logic        out_err_frame,
  output logic        out_err_seq,
  output logic        out_err_match,
  output logic [23:0] ev_trig,
  output logic [11:0] ev_bxn,
  output logic [7:0]  ev_crate,
  output logic [3:0]  ev_board
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BODY, S_TRL} st_t;

  st_t         st, st_nx;
  logic [1:0]  cnt;
  logic [47:0] held;

  assign in_ready = !out_valid || out_ready;

  wire        take     = in_valid && in_ready;
  wire        grp_done = take && (cnt == 2'd3);
  wire [63:0] grp      = {in_word, held};
  wire [3:0]  code     = grp[15:12];
  wire        any_ctl  = grp[15] | grp[31] | grp[47] | grp[63];
  wire        same_nib = (grp[31:28] == code) && (grp[47:44] == code) && (grp[63:60] == code);
  wire        ctl      = any_ctl && same_nib;

  logic frm, seq, mat, last, lone, cap_h1, cap_h2;

  always_comb begin
    st_nx  = st;
    frm    = 1'b0;
    seq    = 1'b0;
    mat    = 1'b0;
    last   = 1'b0;
    lone   = 1'b0;
    cap_h1 = 1'b0;
    cap_h2 = 1'b0;
    if (any_ctl && !same_nib) begin
      frm   = 1'b1;
      last  = (st != S_IDLE);
      st_nx = S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          if (ctl && code == HDR1_CODE) begin
            cap_h1 = 1'b1;
            st_nx  = S_HDR;
          end else if (ctl && code == LONE_CODE) begin
            cap_h1 = 1'b1;
            lone   = 1'b1;
            last   = 1'b1;
          end else begin
            seq = 1'b1;
          end
        end
        S_HDR: begin
          if (ctl && code == HDR2_CODE) begin
            cap_h2 = 1'b1;
            st_nx  = S_BODY;
          end else begin
            seq   = 1'b1;
            last  = 1'b1;
            st_nx = S_IDLE;
          end
        end
        S_BODY: begin
          if (ctl && code == TRL1_CODE) begin
            mat   = (grp[7:0] != ev_trig[7:0]);
            st_nx = S_TRL;
          end else if (ctl && (code == LONE_CODE || code == HDR1_CODE ||
                               code == HDR2_CODE || code == TRL2_CODE)) begin
            seq   = 1'b1;
            last  = 1'b1;
            st_nx = S_IDLE;
          end
        end
        default: begin
          last  = 1'b1;
          st_nx = S_IDLE;
          if (ctl && code == TRL2_CODE) mat = (grp[27:16] != {ev_crate, ev_board});
          else seq = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      cnt           <= 2'd0;
      held          <= '0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_last      <= 1'b0;
      out_lone      <= 1'b0;
      out_err_frame <= 1'b0;
      out_err_seq   <= 1'b0;
      out_err_match <= 1'b0;
      ev_trig       <= '0;
      ev_bxn        <= '0;
      ev_crate      <= '0;
      ev_board      <= '0;
    end else begin
      if (take) begin
        cnt  <= cnt + 2'd1;
        held <= {in_word, held[47:16]};
      end
      if (grp_done) begin
        st            <= st_nx;
        out_valid     <= 1'b1;
        out_data      <= grp;
        out_last      <= last;
        out_lone      <= lone;
        out_err_frame <= frm;
        out_err_seq   <= seq;
        out_err_match <= mat;
        if (cap_h1) begin
          ev_trig <= {grp[27:16], grp[11:0]};
          ev_bxn  <= grp[59:48];
        end
        if (cap_h2) begin
          ev_crate <= grp[27:20];
          ev_board <= grp[19:16];
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

module evt_frame_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_last,
  input logic        out_lone,
  input logic        out_err_frame,
  input logic        out_err_seq
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R3

  AST_LOAD_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R2

  AST_LONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_lone |-> out_last && !out_err_seq); // R6

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_err_frame && out_err_seq)); // R4

  AST_FRAME_NOT_LONE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err_frame |-> !out_lone); // R4

endmodule

bind evt_frame_parser evt_frame_parser_chk u_chk (.*);

// File: tb/tb_evt_frame_parser.sv
module tb_evt_frame_parser;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [15:0] in_word = '0;
  logic [63:0] out_data;
  logic out_last, out_lone, out_err_frame, out_err_seq, out_err_match;
  logic [23:0] ev_trig;
  logic [11:0] ev_bxn;
  logic [7:0]  ev_crate;
  logic [3:0]  ev_board;

  evt_frame_parser dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [63:0] data;
    logic last, lone, frm, seq, mat;
    logic [23:0] trig;
    logic [11:0] bxn;
    logic [7:0]  crate;
    logic [3:0]  board;
  } rec_t;

  logic [15:0] stim[$];
  logic [15:0] acc[$];
  rec_t  expq[$];
  string tagq[$];
  int nchk = 0, nfail = 0, cyc = 0, ngrp_exp = 0, ngrp_got = 0;
  bit go = 0, prev_stall = 0;
  logic [63:0] prev_data;

  int mst = 0;
  logic [23:0] m_trig = 0;
  logic [11:0] m_bxn = 0;
  logic [7:0]  m_crate = 0;
  logic [3:0]  m_board = 0;

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl_grp(logic [3:0] n, logic [11:0] a, logic [11:0] b, logic [11:0] c, logic [11:0] d);
    stim.push_back({n, a}); stim.push_back({n, b});
    stim.push_back({n, c}); stim.push_back({n, d});
  endtask

  task automatic dat_grp(int seed);
    for (int k = 0; k < 4; k++) stim.push_back(16'((seed * 4 + k) * 16'h1357) & 16'h7fff);
  endtask

  task automatic model_push(logic [15:0] w);
    rec_t r;
    logic [15:0] a, b, c, d;
    bit ctl, same;
    logic [3:0] code;
    string tag;
    acc.push_back(w);
    if (acc.size() < 4) return;
    a = acc[0]; b = acc[1]; c = acc[2]; d = acc[3];
    acc.delete();
    r = '0;
    r.data = {d, c, b, a};
    ctl  = a[15] || b[15] || c[15] || d[15];
    code = a[15:12];
    same = (b[15:12] == code) && (c[15:12] == code) && (d[15:12] == code);
    if (ctl && !same) begin
      r.frm = 1; r.last = (mst != 0); mst = 0; tag = "R4";
    end else if (mst == 0) begin
      if (ctl && code == 4'h9) begin
        m_trig = {b[11:0], a[11:0]}; m_bxn = d[11:0]; mst = 1; tag = "R7";
      end else if (ctl && code == 4'h8) begin
        m_trig = {b[11:0], a[11:0]}; m_bxn = d[11:0]; r.lone = 1; r.last = 1; tag = "R6";
      end else begin
        r.seq = 1; tag = "R5";
      end
    end else if (mst == 1) begin
      tag = "R7";
      if (ctl && code == 4'hA) begin
        m_crate = b[11:4]; m_board = b[3:0]; mst = 2;
      end else begin
        r.seq = 1; r.last = 1; mst = 0;
      end
    end else if (mst == 2) begin
      tag = "R8";
      if (ctl && code == 4'hF) begin
        r.mat = (a[7:0] != m_trig[7:0]); mst = 3; tag = "R10";
      end else if (ctl && (code == 4'h8 || code == 4'h9 || code == 4'hA || code == 4'hE)) begin
        r.seq = 1; r.last = 1; mst = 0;
      end
    end else begin
      r.last = 1; mst = 0; tag = "R9";
      if (ctl && code == 4'hE) begin
        r.mat = (b[11:0] != {m_crate, m_board});
        if (r.mat) tag = "R10";
      end else r.seq = 1;
    end
    r.trig = m_trig; r.bxn = m_bxn; r.crate = m_crate; r.board = m_board;
    expq.push_back(r); tagq.push_back(tag);
    ngrp_exp++;
  endtask

  always @(negedge clk) begin
    if (go) begin
      cyc++;
      out_ready = ((cyc % 5) != 3) && ((cyc % 23) < 18);
      in_valid  = (stim.size() > 0) && ((cyc % 7) != 2);
      in_word   = (stim.size() > 0) ? stim[0] : 16'h0;
      #1;
      check(in_ready == (!out_valid || out_ready), "R3 ready", {127'b0, in_ready}, {127'b0, (!out_valid || out_ready)});
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R3 hold", out_data, prev_data);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        ngrp_got++;
        if (expq.size() == 0) check(0, "R2 extra group", out_data, 0);
        else begin
          rec_t e, g;
          string t;
          e = expq.pop_front(); t = tagq.pop_front();
          g = {out_data, out_last, out_lone, out_err_frame, out_err_seq, out_err_match,
               ev_trig, ev_bxn, ev_crate, ev_board};
          check(g.data == e.data, "R2 data", g.data, e.data);
          check(g[63:0] == e[63:0], {t, " flags/fields"}, {64'b0, g[63:0]}, {64'b0, e[63:0]});
        end
      end
      if (in_valid && in_ready) model_push(stim.pop_front());
    end
  end

  initial begin
    // lone event (R6)
    ctl_grp(4'h8, 12'h234, 12'h001, 12'h000, 12'h5A5);
    // clean event (R7, R8, R9, R10)
    ctl_grp(4'h9, 12'h0C7, 12'h0AB, 12'h3F1, 12'h777);
    ctl_grp(4'hA, 12'h000, 12'h5B3, 12'h010, 12'h0C7);
    dat_grp(1); dat_grp(2);
    ctl_grp(4'hF, 12'h7C7, 12'h000, 12'h000, 12'h000);
    ctl_grp(4'hE, 12'h000, 12'h5B3, 12'h123, 12'h456);
    // trailer mismatches (R10)
    ctl_grp(4'h9, 12'h011, 12'h022, 12'h000, 12'h033);
    ctl_grp(4'hA, 12'h000, 12'h124, 12'h000, 12'h000);
    dat_grp(3);
    ctl_grp(4'hF, 12'h012, 12'h000, 12'h000, 12'h000);
    ctl_grp(4'hE, 12'h000, 12'h125, 12'h000, 12'h000);
    // data outside event, then a trailer outside event (R5)
    dat_grp(4);
    ctl_grp(4'hF, 12'h000, 12'h000, 12'h000, 12'h000);
    // header with inconsistent nibble (R4)
    ctl_grp(4'h9, 12'h001, 12'h002, 12'h003, 12'h004);
    stim[stim.size()-2] = 16'hA003;
    // header followed by data (R7)
    ctl_grp(4'h9, 12'h101, 12'h202, 12'h000, 12'h303);
    dat_grp(5);
    // trailer 2 without trailer 1 (R8)
    ctl_grp(4'h9, 12'h111, 12'h222, 12'h000, 12'h333);
    ctl_grp(4'hA, 12'h000, 12'h999, 12'h000, 12'h000);
    dat_grp(6);
    ctl_grp(4'hE, 12'h000, 12'h999, 12'h000, 12'h000);
    // trailer 1 followed by data (R9)
    ctl_grp(4'h9, 12'h044, 12'h055, 12'h000, 12'h066);
    ctl_grp(4'hA, 12'h000, 12'h321, 12'h000, 12'h000);
    ctl_grp(4'hF, 12'h044, 12'h000, 12'h000, 12'h000);
    dat_grp(7);
    // status group in body, header in body (R8)
    ctl_grp(4'h9, 12'h0AA, 12'h0BB, 12'h000, 12'h0CC);
    ctl_grp(4'hA, 12'h000, 12'h456, 12'h000, 12'h000);
    ctl_grp(4'hB, 12'h012, 12'h034, 12'h056, 12'h078);
    ctl_grp(4'h9, 12'h000, 12'h000, 12'h000, 12'h000);
    // misaligned control word in body (R4)
    ctl_grp(4'h9, 12'h0DD, 12'h0EE, 12'h000, 12'h0FF);
    ctl_grp(4'hA, 12'h000, 12'h777, 12'h000, 12'h000);
    dat_grp(8);
    stim[stim.size()-3] = 16'hF000;
    // lone after everything (R6)
    ctl_grp(4'h8, 12'hFFF, 12'hFFF, 12'h000, 12'hFFF);

    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R1 handshake", {out_valid, in_ready}, 2'b01);
    check(ev_trig == 0 && ev_bxn == 0 && ev_crate == 0 && ev_board == 0, "R1 fields",
          {ev_trig, ev_bxn, ev_crate, ev_board}, 0);
    go = 1;
    while ((stim.size() > 0 || expq.size() > 0 || acc.size() > 0 || out_valid) && cyc < 20000)
      @(posedge clk);
    if (cyc >= 20000) check(0, "watchdog", cyc, 20000);
    @(negedge clk);
    check(ngrp_got == ngrp_exp, "R2 group count", ngrp_got, ngrp_exp);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule